// File: doc/BRIEF.md
# Sticky Condition Code Register

This block keeps the low status byte of a fixed-point DSP datapath. After each instruction the datapath presents single-cycle strobes: an ALU result strobe with its zero, overflow and carry flags, an accumulator-store strobe with the 36-bit value going to data memory, a strobe for limiting that happened during an accumulator move (single or parallel), and a strobe for saturation that happened inside a register-to-register transfer. Software may also load the whole byte directly.

Two of the bits latch. The growth bit records that an accumulator written to memory had its bits 30 and 29 differing, which tells a block-floating-point loop such as an FFT pass to scale its data before the next pass. The limit bit records any ALU overflow or any limiting on a move. A saturation that occurs within a register transfer never sets it. Both stay set until reset or an explicit software write. The zero, overflow and carry bits are ordinary flags that load only with a valid ALU result.

Top module: `sticky_ccr`

## Requirements
- R1: A synchronous active-high reset clears every bit of the byte and all flag outputs to 0 on the next clock edge.
- R2: A store strobe whose value has bit 30 different from bit 29 sets the growth bit (byte bit 7) on the following edge.
- R3: The growth bit is left unchanged by a store whose bits 30 and 29 are equal, whatever the other bits are, and by store data presented without the store strobe.
- R4: An ALU result strobe with overflow asserted sets the limit bit (byte bit 6) on the following edge.
- R5: A move-limiting strobe sets the limit bit on the following edge.
- R6: Saturation inside a register-to-register transfer, by itself, leaves the limit bit unchanged.
- R7: Once set, the growth and limit bits hold through any number of cycles until reset or a software write that loads 0 into them.
- R8: Zero (bit 2), overflow (bit 1) and carry (bit 0) load from the ALU flags on a cycle with the ALU result strobe and otherwise hold their value.
- R9: The byte reads growth at bit 7, limit at bit 6, zeros at bits 5 to 3, zero flag at bit 2, overflow at bit 1 and carry at bit 0; the individual flag outputs equal those byte bits; written ones in bits 5 to 3 are discarded.
- R10: A software write loads all five flags; when a hardware set of the growth or limit bit falls in the same cycle, that set is ORed on top of the written value, while for zero, overflow and carry the written value takes priority over the ALU strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_vld | input | 1 | ALU result strobe |
| alu_zero | input | 1 | Result was zero |
| alu_ovf | input | 1 | Result overflowed its destination |
| alu_carry | input | 1 | Carry-out or borrow occurred |
| st_vld | input | 1 | Accumulator store to data memory |
| st_data | input | 36 | Accumulator value being stored |
| mv_lim | input | 1 | Limiting occurred during an accumulator move |
| xfer_sat | input | 1 | Saturation occurred inside a register transfer |
| sw_we | input | 1 | Software write of the byte |
| sw_wdata | input | 8 | Value written by software |
| ccr | output | 8 | Packed condition-code byte |
| sz | output | 1 | Sticky growth bit |
| lim | output | 1 | Sticky limit bit |
| z | output | 1 | Zero flag |
| v | output | 1 | Overflow flag |
| c | output | 1 | Carry flag |

## Verification
The bench builds the block with its default parameters: a 36-bit accumulator with the growth test on bits 30 and 29. That brings within reach store values whose upper guard bits and low bits disagree with the tested pair, so the growth decision is shown to depend only on those two bits. A single table then drives the collisions of software writes with hardware set events and ALU strobes in the same cycle.

// File: rtl/sticky_ccr_pkg.sv
package sticky_ccr_pkg;
  localparam int CCR_W    = 8;
  localparam int POS_C    = 0;
  localparam int POS_V    = 1;
  localparam int POS_Z    = 2;
  localparam int POS_L    = 6;
  localparam int POS_SZ   = 7;
  localparam int N_STICKY = 2;
  localparam int N_RES    = 3;
  typedef enum int {STK_SZ = 0, STK_L = 1} sticky_idx_e;
  typedef enum int {RES_C = 0, RES_V = 1, RES_Z = 2} res_idx_e;
endpackage

// File: rtl/ccr_sticky_bits.sv
module ccr_sticky_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic         sw_we,
  input  logic [N-1:0] sw_val,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= 1'b0;
      else if (sw_we) q[i] <= sw_val[i] | hw_set[i];
      else            q[i] <= q[i] | hw_set[i];
    end
  end
endmodule

// File: rtl/ccr_result_flags.sv
module ccr_result_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         sw_we,
  input  logic [N-1:0] sw_val,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= 1'b0;
      else if (sw_we) q[i] <= sw_val[i];
      else if (load)  q[i] <= load_val[i];
    end
  end
endmodule

// File: rtl/sticky_ccr.sv
module sticky_ccr
  import sticky_ccr_pkg::*;
#(
  parameter int ACC_W   = 36,
  parameter int GROW_HI = 30,
  parameter int GROW_LO = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alu_vld,
  input  logic             alu_zero,
  input  logic             alu_ovf,
  input  logic             alu_carry,
  input  logic             st_vld,
  input  logic [ACC_W-1:0] st_data,
  input  logic             mv_lim,
  input  logic             xfer_sat,
  input  logic             sw_we,
  input  logic [CCR_W-1:0] sw_wdata,
  output logic [CCR_W-1:0] ccr,
  output logic             sz,
  output logic             lim,
  output logic             z,
  output logic             v,
  output logic             c
);
  logic [N_STICKY-1:0] stk_set, stk_sw, stk_q;
  logic [N_RES-1:0]    res_in, res_sw, res_q;

  // growth test looks only at the two guard-adjacent bits
  always_comb begin
    stk_set[STK_SZ] = st_vld & (st_data[GROW_HI] ^ st_data[GROW_LO]);
    // transfer saturation deliberately does not contribute
    stk_set[STK_L]  = (alu_vld & alu_ovf) | mv_lim;
    stk_sw[STK_SZ]  = sw_wdata[POS_SZ];
    stk_sw[STK_L]   = sw_wdata[POS_L];
    res_in[RES_C]   = alu_carry;
    res_in[RES_V]   = alu_ovf;
    res_in[RES_Z]   = alu_zero;
    res_sw[RES_C]   = sw_wdata[POS_C];
    res_sw[RES_V]   = sw_wdata[POS_V];
    res_sw[RES_Z]   = sw_wdata[POS_Z];
  end

  ccr_sticky_bits #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst(rst), .hw_set(stk_set),
    .sw_we(sw_we), .sw_val(stk_sw), .q(stk_q)
  );

  ccr_result_flags #(.N(N_RES)) u_res (
    .clk(clk), .rst(rst), .load(alu_vld), .load_val(res_in),
    .sw_we(sw_we), .sw_val(res_sw), .q(res_q)
  );

  always_comb begin
    ccr         = '0;
    ccr[POS_SZ] = stk_q[STK_SZ];
    ccr[POS_L]  = stk_q[STK_L];
    ccr[POS_Z]  = res_q[RES_Z];
    ccr[POS_V]  = res_q[RES_V];
    ccr[POS_C]  = res_q[RES_C];
  end

  assign sz  = stk_q[STK_SZ];
  assign lim = stk_q[STK_L];
  assign z   = res_q[RES_Z];
  assign v   = res_q[RES_V];
  assign c   = res_q[RES_C];
endmodule

// File: rtl/sticky_ccr_chk.sv
module sticky_ccr_chk #(
  parameter int ACC_W   = 36,
  parameter int GROW_HI = 30,
  parameter int GROW_LO = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             alu_vld,
  input logic             alu_ovf,
  input logic             st_vld,
  input logic [ACC_W-1:0] st_data,
  input logic             mv_lim,
  input logic             xfer_sat,
  input logic             sw_we,
  input logic [7:0]       ccr,
  input logic             sz,
  input logic             lim,
  input logic             z,
  input logic             v,
  input logic             c
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (ccr == 8'h00));
  // R2
  growth_set_chk: assert property (@(posedge clk) disable iff (rst)
    (st_vld && (st_data[GROW_HI] != st_data[GROW_LO])) |=> sz);
  // R4
  ovf_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_vld && alu_ovf) |=> lim);
  // R5
  move_limit_chk: assert property (@(posedge clk) disable iff (rst)
    mv_lim |=> lim);
  // R6
  xfer_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!lim && xfer_sat && !mv_lim && !(alu_vld && alu_ovf) && !sw_we) |=> !lim);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sz && lim && !sw_we) |=> (sz && lim));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!alu_vld && !sw_we) |=> $stable({z, v, c}));
  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ccr[5:3] == 3'b000) && (ccr[7] == sz) && (ccr[0] == c));
endmodule

bind sticky_ccr sticky_ccr_chk #(.ACC_W(ACC_W), .GROW_HI(GROW_HI), .GROW_LO(GROW_LO)) u_chk (
  .clk(clk), .rst(rst), .alu_vld(alu_vld), .alu_ovf(alu_ovf),
  .st_vld(st_vld), .st_data(st_data), .mv_lim(mv_lim), .xfer_sat(xfer_sat),
  .sw_we(sw_we), .ccr(ccr), .sz(sz), .lim(lim), .z(z), .v(v), .c(c)
);

// File: tb/sim_sticky_ccr.sv
module sim_sticky_ccr;
  logic        clk = 1'b0;
  logic        rst;
  logic        alu_vld, alu_zero, alu_ovf, alu_carry;
  logic        st_vld;
  logic [35:0] st_data;
  logic        mv_lim, xfer_sat, sw_we;
  logic [7:0]  sw_wdata;
  logic [7:0]  ccr;
  logic        sz, lim, z, v, c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sticky_ccr u0 (
    .clk(clk), .rst(rst), .alu_vld(alu_vld), .alu_zero(alu_zero),
    .alu_ovf(alu_ovf), .alu_carry(alu_carry), .st_vld(st_vld),
    .st_data(st_data), .mv_lim(mv_lim), .xfer_sat(xfer_sat),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .ccr(ccr), .sz(sz), .lim(lim),
    .z(z), .v(v), .c(c)
  );

  typedef struct packed {
    logic        alu;
    logic [2:0]  zvc;
    logic        st;
    logic [35:0] acc;
    logic        ml;
    logic        xs;
    logic        we;
    logic [7:0]  wd;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'b100, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04}, // R8 zero loads
    '{1'b0, 3'b000, 1'b0, 36'h0_0000_0000, 1'b0, 1'b1, 1'b0, 8'h00, 8'h04}, // R6 transfer sat only
    '{1'b0, 3'b000, 1'b1, 36'h0_6000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04}, // R3 bits 11
    '{1'b0, 3'b000, 1'b1, 36'hF_9FFF_FFFF, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04}, // R3 bits 00, others set
    '{1'b0, 3'b000, 1'b0, 36'h0_2000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04}, // R3 no strobe
    '{1'b0, 3'b000, 1'b1, 36'h0_2000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h84}, // R2 bits 01
    '{1'b1, 3'b001, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81}, // R8 carry
    '{1'b0, 3'b000, 1'b0, 36'h0_0000_0000, 1'b1, 1'b0, 1'b0, 8'h00, 8'hC1}, // R5 move limit
    '{1'b0, 3'b000, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00}, // R7 software clear
    '{1'b1, 3'b010, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h42}, // R4 overflow
    '{1'b1, 3'b000, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40}, // R7 limit holds
    '{1'b0, 3'b000, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1, 8'h3F, 8'h07}, // R9 pad bits dropped
    '{1'b1, 3'b111, 1'b1, 36'h0_4000_0000, 1'b0, 1'b0, 1'b1, 8'h00, 8'hC0}, // R10 collision
    '{1'b0, 3'b000, 1'b0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hC7}  // R9 full write
  };

  task automatic idle();
    alu_vld = 0; alu_zero = 0; alu_ovf = 0; alu_carry = 0;
    st_vld = 0; st_data = '0; mv_lim = 0; xfer_sat = 0;
    sw_we = 0; sw_wdata = '0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", ccr, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      alu_vld = VEC[i].alu;
      {alu_zero, alu_ovf, alu_carry} = VEC[i].zvc;
      st_vld = VEC[i].st; st_data = VEC[i].acc;
      mv_lim = VEC[i].ml; xfer_sat = VEC[i].xs;
      sw_we = VEC[i].we; sw_wdata = VEC[i].wd;
      @(negedge clk);
      idle();
      check($sformatf("R%0s vec %0d", "x", i), ccr, VEC[i].exp);
      // R9 individual outputs agree with the byte
      check("R9 flags", {sz, lim, 3'b000, z, v, c}, ccr);
    end
    // R7 sticky bits survive idle cycles
    repeat (4) @(negedge clk);
    check("R7 idle hold", ccr, 8'hC7);
    // R6 repeated transfer saturation after software clear
    sw_we = 1; sw_wdata = 8'h00;
    @(negedge clk);
    sw_we = 0; xfer_sat = 1;
    repeat (3) @(negedge clk);
    xfer_sat = 0;
    check("R6 transfer sat", ccr, 8'h00);
    // R2 then R1: reset clears set bits
    st_vld = 1; st_data = 36'h8_5000_0000;
    mv_lim = 1;
    @(negedge clk);
    idle();
    check("R2 R5 set", ccr, 8'hC0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset clears", ccr, 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule